// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter with Offset Restart

This block is a synchronous binary up-counter, four bits wide by default, that several copies can chain into a wider counter. It advances only when two count enables are both high. The first enable gates the local stage only. The second enable also gates the terminal-count carry, so a lower stage's carry can drive the next stage's second enable directly. All state changes happen on the rising clock edge, including the active-low clear and the active-low parallel load.

A mode input turns the counter into an offset counter. While that mode is set, the terminal-count carry acts as a load request. After the all-ones state the counter therefore restarts at the value on the load inputs instead of at zero. With a load value of 0110 the counter cycles 0110, 0111, ..., 1111, 0110, ...

The block also has a synchronous active-high reset. Its effect on the state is the same as the clear input.

Top module: `cascade_counter`

## Requirements
- R1: When `rst` is high or `clr_n` is low at a rising edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R2: When `clr_n` and `ld_n` are both low at the same edge, the clear wins and `count` becomes 0.
- R3: When `ld_n` is low and `clr_n` is high, `count` takes `ld_val` at the edge, whether or not the enables are high.
- R4: When there is no clear and no load (external or offset) and both `en_p` and `en_t` are high, `count` increases by one at the edge.
- R5: When there is no clear and no load and `en_p` or `en_t` is low, `count` keeps its value.
- R6: `carry` is combinational and equals `en_t` AND (`count` is all ones). It does not depend on `en_p`.
- R7: With `offset_mode` low, a count step from all ones gives 0.
- R8: With `offset_mode` high, an edge at which `carry` is high (and `clr_n` is high) loads `ld_val`. This happens even when `en_p` is low. A load value of 0110 gives the cycle 0110 through 1111 and back to 0110.
- R9: With `offset_mode` high, `count` at all ones and `en_t` low, there is no reload and the state holds.
- R10: Clear takes priority over the offset reload: clear, then load, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_n | input | 1 | Synchronous active-low clear |
| ld_n | input | 1 | Synchronous active-low parallel load |
| ld_val | input | WIDTH | Parallel load / offset restart value |
| en_p | input | 1 | Count enable, local only |
| en_t | input | 1 | Count enable, also gates carry |
| offset_mode | input | 1 | When high, carry forces a reload of ld_val |
| count | output | WIDTH | Registered counter state |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
Clear and load can fall in the same cycle. So can clear and the offset reload, and an external load and a count step. The bench drives `clr_n` and `ld_n` low together. It also drops `clr_n` while the counter sits at all ones in offset mode with `en_t` high, and it asserts `ld_n` with both enables high. A reference model with the stated priority predicts each outcome, and the design must give 0 for the first two cases and the load value for the third. The bench also holds the counter at all ones with `en_t` low in offset mode, where the carry and the reload must both stay inactive.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/cnt_priority.sv
module cnt_priority
  import cascade_counter_pkg::*;
(
  input  logic     rst,
  input  logic     clr_n,
  input  logic     ld_n,
  input  logic     reload,
  input  logic     en_p,
  input  logic     en_t,
  output cnt_act_e act
);
  // Fixed order: clear, load (external or offset), count, hold.
  always_comb begin
    if (rst || !clr_n)          act = ACT_CLEAR;
    else if (!ld_n || reload)   act = ACT_LOAD;
    else if (en_p && en_t)      act = ACT_COUNT;
    else                        act = ACT_HOLD;
  end

  // R10: whenever clear is requested no other action may be chosen
  always_comb begin
    if (!clr_n) assert (act == ACT_CLEAR) else $error("p_clear_first_r10");
  end
endmodule

// File: rtl/cnt_incr.sv
module cnt_incr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt,
  output logic             all_ones
);
  logic [WIDTH:0] tog;

  assign tog[0] = 1'b1;

  // Toggle chain: bit i flips when all lower bits are one.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign nxt[i]     = cur[i] ^ tog[i];
    assign tog[i + 1] = tog[i] & cur[i];
  end

  assign all_ones = tog[WIDTH];
endmodule

// File: rtl/cnt_state.sv
module cnt_state
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_act_e         act,
  input  logic [WIDTH-1:0] ld_val,
  input  logic [WIDTH-1:0] inc_val,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    unique case (act)
      ACT_CLEAR: q <= '0;
      ACT_LOAD:  q <= ld_val;
      ACT_COUNT: q <= inc_val;
      default:   q <= q;
    endcase
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> $stable(q));
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             en_p,
  input  logic             en_t,
  input  logic             offset_mode,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TERM = {WIDTH{1'b1}};

  cnt_act_e         act;
  logic [WIDTH-1:0] inc_val;
  logic             at_term;
  logic             reload;

  cnt_incr #(.WIDTH(WIDTH)) u_incr (
    .cur      (count),
    .nxt      (inc_val),
    .all_ones (at_term)
  );

  // Carry is gated by en_t only, so it can feed the next stage's en_t.
  assign carry  = en_t & at_term;
  assign reload = offset_mode & carry;

  cnt_priority u_prio (
    .rst    (rst),
    .clr_n  (clr_n),
    .ld_n   (ld_n),
    .reload (reload),
    .en_p   (en_p),
    .en_t   (en_t),
    .act    (act)
  );

  cnt_state #(.WIDTH(WIDTH)) u_state (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .ld_val  (ld_val),
    .inc_val (inc_val),
    .q       (count)
  );

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (count == '0));
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n) |=> (count == $past(ld_val)));
  p_count_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !(offset_mode && carry) && en_p && en_t)
      |=> (count == $past(count) + WIDTH'(1)));
  p_carry_r6: assert property (@(posedge clk) disable iff (rst)
    carry |-> (en_t && count == TERM));
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !offset_mode && en_p && en_t && count == TERM)
      |=> (count == '0));
  p_offset_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_n && offset_mode && carry) |=> (count == $past(ld_val)));
endmodule

// File: tb/cascade_counter_bench.sv
module cascade_counter_bench;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_n = 1'b1;
  logic         ld_n = 1'b1;
  logic [W-1:0] ld_val = '0;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;
  logic         offset_mode = 1'b0;
  logic [W-1:0] count;
  logic         carry;

  always #5 clk = ~clk;

  cascade_counter #(.WIDTH(W)) u_cascade_counter (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ld_n(ld_n), .ld_val(ld_val),
    .en_p(en_p), .en_t(en_t), .offset_mode(offset_mode),
    .count(count), .carry(carry)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [W-1:0] exp_q_q[$];
  logic         exp_c_q[$];
  string        tag_q[$];
  logic [W-1:0] model = '0;

  // Driver: set inputs after a falling edge, predict the state after the next rising edge.
  task automatic step(input logic r, input logic c, input logic l, input logic p,
                      input logic t, input logic m, input logic [W-1:0] v,
                      input string tag);
    logic [W-1:0] nx;
    @(negedge clk);
    rst = r; clr_n = c; ld_n = l; en_p = p; en_t = t; offset_mode = m; ld_val = v;
    if (r || !c)                           nx = '0;
    else if (!l || (m && t && model == TOP)) nx = v;
    else if (p && t)                       nx = model + W'(1);
    else                                   nx = model;
    model = nx;
    exp_q_q.push_back(nx);
    exp_c_q.push_back(t && nx == TOP);
    tag_q.push_back(tag);
  endtask

  // Monitor: just after each rising edge compare against the oldest prediction.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q_q.size() > 0) begin
        logic [W-1:0] eq;
        logic         ec;
        string        tg;
        eq = exp_q_q.pop_front();
        ec = exp_c_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (count !== eq || carry !== ec) begin
          failures++;
          $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b",
                   tg, count, carry, eq, ec);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1, 1, 1, 1, 1, 0, 4'h9, "R1 reset");
    step(1, 1, 0, 1, 1, 1, 4'h9, "R1 reset over load");
    // R4: plain counting
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, 0, 4'h0, "R4 count");
    // R3: load with enables low
    step(0, 1, 0, 0, 0, 0, 4'hD, "R3 load no enable");
    // R3: load with both enables high (load beats count)
    step(0, 1, 0, 1, 1, 0, 4'hC, "R3 load beats count");
    step(0, 1, 1, 1, 1, 0, 4'h0, "R4 count to D");
    step(0, 1, 1, 1, 1, 0, 4'h0, "R4 count to E");
    step(0, 1, 1, 1, 1, 0, 4'h0, "R6 count to F carry high");
    // R5/R6: hold at F with en_p low, carry still high
    step(0, 1, 1, 0, 1, 0, 4'h0, "R5 hold p low, R6 carry");
    // R6: en_t low drops carry, state holds
    step(0, 1, 1, 1, 0, 0, 4'h0, "R6 carry gated by en_t");
    // R7: wrap to zero
    step(0, 1, 1, 1, 1, 0, 4'h0, "R7 wrap to zero");
    step(0, 1, 1, 1, 1, 0, 4'h0, "R4 count after wrap");
    // R2: clear beats load
    step(0, 0, 0, 1, 1, 0, 4'hA, "R2 clear beats load");
    step(0, 1, 0, 0, 0, 0, 4'h5, "R3 load 5");
    step(0, 0, 1, 1, 1, 0, 4'h0, "R1 clear alone");
    // R8: offset counter with restart value 0110
    step(0, 1, 0, 0, 0, 1, 4'h6, "R8 preload 6");
    for (int i = 0; i < 9; i++) step(0, 1, 1, 1, 1, 1, 4'h6, "R8 offset count");
    step(0, 1, 1, 1, 1, 1, 4'h6, "R8 restart at 6");
    step(0, 1, 1, 1, 1, 1, 4'h6, "R8 count after restart");
    // R8: reload happens with en_p low
    step(0, 1, 0, 0, 0, 1, 4'hF, "R3 load F");
    step(0, 1, 1, 0, 1, 1, 4'h3, "R8 reload with p low");
    // R9: no reload when en_t low
    step(0, 1, 0, 0, 0, 1, 4'hF, "R3 load F again");
    step(0, 1, 1, 1, 0, 1, 4'h3, "R9 no reload t low");
    step(0, 1, 1, 1, 0, 1, 4'h3, "R9 still holding");
    // R10: clear beats offset reload
    step(0, 0, 1, 1, 1, 1, 4'h3, "R10 clear beats reload");
    // R5: en_t low alone holds
    step(0, 1, 1, 1, 0, 0, 4'h0, "R5 hold t low");
    step(0, 1, 1, 1, 1, 0, 4'h0, "R4 final count");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule